// File: doc/BRIEF.md
# System Control Register File with Interrupt Combiner

This block is the system-control register space of a multi-function companion chip. A host reaches every register one byte at a time through an 8-bit port: a byte address, a write strobe with write data, and a read data byte that always reflects the addressed location. Registers wider than a byte are split into byte lanes that are read and written separately. Most registers are plain configuration storage; their contents drive nothing inside this block.

Eight sub-device interrupt lines come in: line 0 from the NAND controller, line 1 from the card interface, line 2 from the USB host, line 3 from the serial port and line 4 from the framebuffer, with lines 5 to 7 spare. Each line is tracked as a level into an interrupt status byte. The status byte is ANDed with a mask byte, and a single registered interrupt output is raised when any enabled status bit is set. A routing byte is stored for software and does not change this block's behaviour.

Top module: `sysctl_regfile`

## Requirements
- R1: A change on sub-interrupt line n is copied into status bit n (address 0x50, bit n = line n) at the next clock edge: a line that rises sets the bit and a line that falls clears it. A line that holds its level leaves the bit alone.
- R2: A host write to the status byte loads every bit whose sub-line did not change in that cycle; in a bit whose sub-line changed in the same cycle, the new line level wins.
- R3: The interrupt output is a register that holds, one clock after the status and mask registers take a value, the OR of all bits of (status AND mask).
- R4: The status byte at 0x50, the mask byte at 0x52 and the routing byte at 0x54 can be written and read back. Every mapped byte address is decoded by exactly one register.
- R5: Address 0x08 always reads 3 and address 0x09 always reads 0; writes to these addresses have no effect.
- R6: Configuration registers store what was written and read it back. Word registers at 0x60, 0x8C, 0x90, 0x94, 0x98, 0x9A and 0xE4 put the low byte at A and the high byte at A+1. The three-byte groups at 0x64, 0x68, 0x6C, 0x70, 0x78, 0x7C, 0x80, 0x84 and 0x88 put byte k at A+k. The single bytes are at 0xA0, 0xA1, 0xE0, 0xFC and 0xFF. A write to one byte lane leaves all other lanes unchanged.
- R7: The 32-bit register at 0x9C exposes byte k (k = 0..3, least significant first) at 0x9C+k, and each byte is written on its own.
- R8: Reads from any address not listed in R4 to R7 return 0. Writes to such addresses change no readable state.
- R9: After reset every register reads 0, except the revision bytes of R5, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed byte |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for addr (combinational) |
| sub_irq | input | 8 | Sub-device interrupt levels, line n to status bit n |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The bench goes after three kinds of collision. A status write in the same cycle as a sub-line edge: a design that lets the host win would lose the edge, and one that lets the line overwrite the whole byte would drop the other written bits. Writes to one byte of a word or long register followed by reads of the neighbouring bytes: a wrong lane decode would corrupt or duplicate a byte. The bench also sweeps all 256 addresses, the revision bytes and the gaps between registers. A design that decoded a gap, or let a write reach the constant revision, would return non-zero data. Interrupt timing is checked every cycle against a one-clock-delayed model, so an output that is combinational or delayed twice is caught.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned ADDR_BITS = 8;
   localparam logic [7:0]  OFS_REV   = 8'h08;
   localparam int unsigned REV_BYTES = 2;
   localparam int unsigned REV_VALUE = 3;
   localparam logic [7:0]  OFS_STAT  = 8'h50;
   localparam logic [7:0]  OFS_MASK  = 8'h52;
   localparam logic [7:0]  OFS_ROUTE = 8'h54;

   // configuration storage: base address and size in bytes
   localparam int unsigned NUM_CFG = 22;
   localparam int unsigned CFG_BASE [NUM_CFG] = '{
      32'h60, 32'h64, 32'h68, 32'h6C, 32'h70, 32'h78, 32'h7C, 32'h80,
      32'h84, 32'h88, 32'h8C, 32'h90, 32'h94, 32'h98, 32'h9A, 32'h9C,
      32'hA0, 32'hA1, 32'hE0, 32'hE4, 32'hFC, 32'hFF};
   localparam int unsigned CFG_SIZE [NUM_CFG] = '{
      2, 3, 3, 3, 3, 3, 3, 3,
      3, 3, 2, 2, 2, 2, 2, 4,
      1, 1, 1, 2, 1, 1};
endpackage

// File: rtl/sysctl_byte_reg.sv
module sysctl_byte_reg #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NBYTES = 2,
   parameter int unsigned BASE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              hit
);
   localparam int unsigned LAST = BASE + NBYTES - 1;

   if (NBYTES < 1 || NBYTES > 4) begin : g_bad_size
      $error("sysctl_byte_reg: NBYTES must be 1 to 4");
   end
   if (LAST >= (1 << ADDR_W)) begin : g_bad_base
      $error("sysctl_byte_reg: register exceeds address space");
   end

   logic [NBYTES-1:0] sel;
   logic [DATA_W-1:0] lane_q [NBYTES];

   for (genvar j = 0; j < NBYTES; j++) begin : g_lane
      localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE + j);
      assign sel[j] = (addr == LANE_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                lane_q[j] <= '0;
         else if (wr_en && sel[j])  lane_q[j] <= wdata;
      end

      AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && sel[j]) |=> $stable(lane_q[j])); // R6
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NBYTES; k++) begin
         if (sel[k]) rd_data = lane_q[k];
      end
   end

   assign hit = |sel;
endmodule

// File: rtl/sysctl_rev_const.sv
module sysctl_rev_const #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned BASE   = 8,
   parameter int unsigned NBYTES = 2,
   parameter int unsigned VALUE  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              hit
);
   localparam int unsigned TOTAL_W = NBYTES * DATA_W;
   localparam logic [TOTAL_W-1:0] VAL_VEC = TOTAL_W'(VALUE);

   if (NBYTES < 1 || NBYTES > 4) begin : g_bad_size
      $error("sysctl_rev_const: NBYTES must be 1 to 4");
   end

   logic [NBYTES-1:0] sel;
   for (genvar j = 0; j < NBYTES; j++) begin : g_sel
      localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE + j);
      assign sel[j] = (addr == LANE_ADDR);
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NBYTES; k++) begin
         if (sel[k]) rd_data = VAL_VEC[k*DATA_W +: DATA_W];
      end
   end

   assign hit = |sel;
endmodule

// File: rtl/sysctl_irq_combiner.sv
module sysctl_irq_combiner #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned N_SUB     = 8,
   parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h50,
   parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h52,
   parameter logic [ADDR_W-1:0] ROUTE_OFS = 8'h54
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N_SUB-1:0]  sub_irq,
   output logic [DATA_W-1:0] rd_data,
   output logic              hit,
   output logic              irq_out
);
   if (N_SUB < 1 || N_SUB > DATA_W) begin : g_bad_sub
      $error("sysctl_irq_combiner: N_SUB must be 1 to DATA_W");
   end

   logic [DATA_W-1:0] status_q, status_d;
   logic [DATA_W-1:0] mask_q, route_q;
   logic [N_SUB-1:0]  sub_seen_q;
   logic              irq_q;
   logic              wr_stat, wr_mask, wr_route;

   assign wr_stat  = wr_en && (addr == STAT_OFS);
   assign wr_mask  = wr_en && (addr == MASK_OFS);
   assign wr_route = wr_en && (addr == ROUTE_OFS);

   // per-bit next status: tracked lines take an edge first, spare bits are host-only
   for (genvar i = 0; i < DATA_W; i++) begin : g_stat
      if (i < N_SUB) begin : g_tracked
         always_comb begin
            if (sub_irq[i] != sub_seen_q[i]) status_d[i] = sub_irq[i];
            else if (wr_stat)                status_d[i] = wdata[i];
            else                             status_d[i] = status_q[i];
         end

         AST_SUB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (sub_irq[i] != sub_seen_q[i]) |=> (status_q[i] == $past(sub_irq[i]))); // R1
         AST_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat && (sub_irq[i] == sub_seen_q[i])) |=> (status_q[i] == $past(wdata[i]))); // R2
      end else begin : g_plain
         always_comb status_d[i] = wr_stat ? wdata[i] : status_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q   <= '0;
         mask_q     <= '0;
         route_q    <= '0;
         sub_seen_q <= '0;
         irq_q      <= 1'b0;
      end else begin
         status_q   <= status_d;
         sub_seen_q <= sub_irq;
         if (wr_mask)  mask_q  <= wdata;
         if (wr_route) route_q <= wdata;
         irq_q      <= |(status_q & mask_q);
      end
   end

   assign irq_out = irq_q;

   always_comb begin
      hit     = 1'b1;
      rd_data = '0;
      if (addr == STAT_OFS)       rd_data = status_q;
      else if (addr == MASK_OFS)  rd_data = mask_q;
      else if (addr == ROUTE_OFS) rd_data = route_q;
      else                        hit = 1'b0;
   end

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status_q & mask_q)) |=> irq_out); // R3
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status_q & mask_q)) |=> !irq_out); // R3
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W = ADDR_BITS,
   parameter int unsigned DATA_W = BYTE_W,
   parameter int unsigned N_SUB  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_SUB-1:0]  sub_irq,
   output logic              irq_out
);
   localparam int unsigned N_SRC = NUM_CFG + 2;

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("sysctl_regfile: the access port is one byte wide");
   end
   if (ADDR_W != ADDR_BITS) begin : g_bad_addr
      $error("sysctl_regfile: register map assumes an 8-bit address");
   end

   logic [DATA_W-1:0] src_data [N_SRC];
   logic [N_SRC-1:0]  src_hit;

   sysctl_rev_const #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BASE   (int'(OFS_REV)),
      .NBYTES (REV_BYTES),
      .VALUE  (REV_VALUE)
   ) i_rev (
      .addr    (addr),
      .rd_data (src_data[0]),
      .hit     (src_hit[0])
   );

   sysctl_irq_combiner #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .N_SUB     (N_SUB),
      .STAT_OFS  (ADDR_W'(OFS_STAT)),
      .MASK_OFS  (ADDR_W'(OFS_MASK)),
      .ROUTE_OFS (ADDR_W'(OFS_ROUTE))
   ) i_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .sub_irq (sub_irq),
      .rd_data (src_data[1]),
      .hit     (src_hit[1]),
      .irq_out (irq_out)
   );

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
      sysctl_byte_reg #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W),
         .NBYTES (CFG_SIZE[g]),
         .BASE   (CFG_BASE[g])
      ) i_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .addr    (addr),
         .wdata   (wdata),
         .rd_data (src_data[g+2]),
         .hit     (src_hit[g+2])
      );
   end

   // decoders are disjoint, so an OR of the sources is the read mux
   always_comb begin
      rdata = '0;
      for (int s = 0; s < N_SRC; s++) rdata = rdata | src_data[s];
   end

   AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_hit)); // R4
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (src_hit == '0) |-> (rdata == '0)); // R8
endmodule

// File: tb/test_sysctl_regfile.sv
module test_sysctl_regfile;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] sub_irq = '0;
   logic       irq_out;

   int errors = 0;
   int checks = 0;

   logic [7:0] mem [256];
   logic [7:0] m_stat = '0, m_mask = '0, m_route = '0, m_prev = '0;
   logic       m_irq = 1'b0;

   sysctl_regfile i_sysctl_regfile (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
      .wdata (wdata), .rdata (rdata), .sub_irq (sub_irq), .irq_out (irq_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic bit is_cfg(input logic [7:0] a);
      return (a >= 8'h60 && a <= 8'h61) || (a >= 8'h64 && a <= 8'h66) ||
             (a >= 8'h68 && a <= 8'h6A) || (a >= 8'h6C && a <= 8'h6E) ||
             (a >= 8'h70 && a <= 8'h72) || (a >= 8'h78 && a <= 8'h7A) ||
             (a >= 8'h7C && a <= 8'h7E) || (a >= 8'h80 && a <= 8'h82) ||
             (a >= 8'h84 && a <= 8'h86) || (a >= 8'h88 && a <= 8'h8A) ||
             (a >= 8'h8C && a <= 8'h8D) || (a >= 8'h90 && a <= 8'h91) ||
             (a >= 8'h94 && a <= 8'h95) || (a >= 8'h98 && a <= 8'h9F) ||
             (a == 8'hA0) || (a == 8'hA1) || (a == 8'hE0) ||
             (a >= 8'hE4 && a <= 8'hE5) || (a == 8'hFC) || (a == 8'hFF);
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      if (a == 8'h08) return 8'd3;
      if (a == 8'h50) return m_stat;
      if (a == 8'h52) return m_mask;
      if (a == 8'h54) return m_route;
      if (is_cfg(a))  return mem[a];
      return 8'h00;
   endfunction

   function automatic string req_of(input logic [7:0] a);
      if (a == 8'h08 || a == 8'h09) return "R5";
      if (a == 8'h50) return "R1";
      if (a == 8'h52 || a == 8'h54) return "R4";
      if (a >= 8'h9C && a <= 8'h9F) return "R7";
      if (is_cfg(a)) return "R6";
      return "R8";
   endfunction

   task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // one clock cycle: drive, optional read check before the edge, model update, irq check after
   task automatic do_cycle(input bit wr, input logic [7:0] a, input logic [7:0] d,
                           input logic [7:0] sub, input bit chk, input string tag);
      logic [7:0] stat_n;
      logic       irq_n;
      @(negedge clk);
      wr_en = wr; addr = a; wdata = d; sub_irq = sub;
      #1;
      if (chk) check((tag == "") ? req_of(a) : tag, $sformatf("read @%h", a), rdata, exp_read(a));
      irq_n  = |(m_stat & m_mask);
      stat_n = m_stat;
      if (wr && a == 8'h50) stat_n = d;
      for (int b = 0; b < 8; b++) if (sub[b] != m_prev[b]) stat_n[b] = sub[b];
      @(posedge clk);
      #1;
      m_stat = stat_n;
      m_prev = sub;
      m_irq  = irq_n;
      if (wr && a == 8'h52) m_mask = d;
      if (wr && a == 8'h54) m_route = d;
      if (wr && is_cfg(a))  mem[a] = d;
      check("R3", "irq_out", {7'd0, irq_out}, {7'd0, m_irq});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] a, d, s;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      void'($urandom(32'h5A17));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9: reset values across the whole map
      check("R9", "irq after reset", {7'd0, irq_out}, 8'h00);
      for (int i = 0; i < 256; i++) do_cycle(1'b0, 8'(i), 8'h00, 8'h00, 1'b1, "R9");

      // R5: revision bytes ignore writes
      do_cycle(1'b1, 8'h08, 8'hAA, 8'h00, 1'b0, "");
      do_cycle(1'b1, 8'h09, 8'h55, 8'h00, 1'b0, "");
      do_cycle(1'b0, 8'h08, 8'h00, 8'h00, 1'b1, "R5");
      do_cycle(1'b0, 8'h09, 8'h00, 8'h00, 1'b1, "R5");

      // R1: lines 0..4 rise, then line 2 falls
      do_cycle(1'b0, 8'h50, 8'h00, 8'h1F, 1'b0, "");
      do_cycle(1'b0, 8'h50, 8'h00, 8'h1F, 1'b1, "R1");
      do_cycle(1'b0, 8'h50, 8'h00, 8'h1B, 1'b0, "");
      do_cycle(1'b0, 8'h50, 8'h00, 8'h1B, 1'b1, "R1");

      // R3: enable line 3 only, irq follows one clock later
      do_cycle(1'b1, 8'h52, 8'h08, 8'h1B, 1'b0, "");
      do_cycle(1'b0, 8'h52, 8'h00, 8'h1B, 1'b1, "R4");
      do_cycle(1'b0, 8'h50, 8'h00, 8'h13, 1'b0, "");
      do_cycle(1'b0, 8'h50, 8'h00, 8'h13, 1'b1, "R3");

      // R2: host write collides with line 0 falling and line 7 rising
      do_cycle(1'b1, 8'h50, 8'h61, 8'h92, 1'b0, "");
      do_cycle(1'b0, 8'h50, 8'h00, 8'h92, 1'b1, "R2");

      // R6: word lanes written separately
      do_cycle(1'b1, 8'h98, 8'h34, 8'h92, 1'b0, "");
      do_cycle(1'b1, 8'h99, 8'h12, 8'h92, 1'b0, "");
      do_cycle(1'b1, 8'h98, 8'hCD, 8'h92, 1'b0, "");
      do_cycle(1'b0, 8'h99, 8'h00, 8'h92, 1'b1, "R6");
      do_cycle(1'b0, 8'h98, 8'h00, 8'h92, 1'b1, "R6");

      // R7: long register bytes
      for (int k = 0; k < 4; k++) do_cycle(1'b1, 8'(8'h9C + k), 8'(8'h11 * (k + 1)), 8'h92, 1'b0, "");
      do_cycle(1'b1, 8'h9E, 8'hEE, 8'h92, 1'b0, "");
      for (int k = 0; k < 4; k++) do_cycle(1'b0, 8'(8'h9C + k), 8'h00, 8'h92, 1'b1, "R7");

      // R8: writes into gaps
      do_cycle(1'b1, 8'h62, 8'hFF, 8'h92, 1'b0, "");
      do_cycle(1'b1, 8'h53, 8'hFF, 8'h92, 1'b0, "");
      do_cycle(1'b0, 8'h62, 8'h00, 8'h92, 1'b1, "R8");
      do_cycle(1'b0, 8'h53, 8'h00, 8'h92, 1'b1, "R8");
      do_cycle(1'b0, 8'h52, 8'h00, 8'h92, 1'b1, "R4");

      // random traffic
      s = 8'h92;
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(3, 0) == 0) a = 8'($urandom_range(255, 0));
         else case ($urandom_range(5, 0))
            0: a = 8'h50;
            1: a = 8'h52;
            2: a = 8'(8'h9C + $urandom_range(3, 0));
            3: a = 8'(8'h60 + $urandom_range(7, 0));
            4: a = 8'(8'h08 + $urandom_range(1, 0));
            default: a = 8'(8'hE0 + $urandom_range(7, 0));
         endcase
         d = 8'($urandom_range(255, 0));
         if ($urandom_range(2, 0) == 0) s = s ^ (8'd1 << $urandom_range(7, 0));
         do_cycle($urandom_range(1, 0) == 1, a, d, s, 1'b1, "");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule